// File: doc/BRIEF.md
# Free-Running Timer with Extended Timestamp

This block is a 16-bit continuous down-counter that advances once for each clock with the step enable high. After zero it passes through one extra all-ones state and then loads the programmed reload value again, so one counter period is `RELOAD + 2` steps. Each arrival at zero flips a half-period output. A registered rising-edge detector on that output advances a 64-bit tick counter and sets a sticky interrupt flag. One tick is therefore worth two counter periods.

A capture strobe freezes the counter value, the half-period bit, the edge-pending condition and the tick count in a single clock. Software can then read the two counter bytes one at a time without getting a torn value. From the frozen fields the block builds a 64-bit timestamp counted in steps.

The tick counter lags the half-period rise by one clock. When a capture falls in that gap, the phase is close to the start of an interval but the tick count is still the old one. The block detects this and adds the missing tick, so the timestamp never steps backwards.

Top module: `stamp_timer`

## Requirements
- R1: After synchronous reset the live counter is 0, the half bit is 1, ticks is 0 and irq is 0. The captured fields match that live state, so `stamp` reads 0 and `rd_byte` reads 0.
- R2: On each clock with `step_en` high, the counter goes from 0 to 0xFFFF, from 0xFFFF to `RELOAD`, and otherwise down by one. With `step_en` low it holds.
- R3: `half_out` inverts exactly on a step that moves the counter from 1 to 0.
- R4: `ticks` increases by one on the clock after each clock in which `half_out` is 1 and was 0 the clock before. Otherwise it holds, so it equals floor(steps/(2·(RELOAD+2))) with one clock of lag.
- R5: `irq` is set on every tick increment and stays set until a clock with `irq_clr` high and no tick increment. A tick increment in the same clock as `irq_clr` leaves `irq` set.
- R6: A clock with `snap` high captures the counter, half bit, pending-edge condition and ticks together. Captured fields hold while `snap` is low. `rd_byte` shows captured bits 15:8 when `rd_hi` is 1 and bits 7:0 when `rd_hi` is 0.
- R7: The in-half offset is 0 for a captured count of 0, 1 for 0xFFFF, and `RELOAD+2−count` otherwise. `stamp` = 2·(RELOAD+2)·ticks + (half ? 0 : RELOAD+2) + offset.
- R8: If the captured half bit is 1, a rising edge was still pending, and the offset is below `EARLY_WIN`, one tick is added to the captured ticks before the formula of R7 is applied. As a result `stamp` equals the number of steps taken before the capturing clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Counter step enable |
| snap | input | 1 | Capture strobe |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| rd_hi | input | 1 | Byte select for the captured counter: 1 = high byte |
| rd_byte | output | 8 | Selected byte of the captured counter |
| stamp | output | 64 | Timestamp in steps, built from the captured fields |
| half_out | output | 1 | Half-period output, flips at each zero |
| irq | output | 1 | Sticky interrupt flag |
| ticks | output | 64 | Live tick count |

## Verification
The bench builds the block with `RELOAD` = 20 and `EARLY_WIN` = 10, which gives a 22-step period and a tick every 44 steps. With that setting, thousands of random clocks cover hundreds of wraps, all-ones steps, half flips and ticks. The random mix varies the step enable, captures, clears and byte selects. It also reaches the exact one-clock gap in which a capture needs the early-edge correction. A directed sequence forces that gap together with a simultaneous clear, so the priority of setting over clearing is exercised.

// File: rtl/stamp_timer_pkg.sv
package stamp_timer_pkg;

    localparam int CNT_W  = 16;
    localparam int TICK_W = 64;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [TICK_W-1:0] tick_t;

    // Fields frozen by one capture strobe
    typedef struct packed {
        cnt_t  cnt;
        logic  half;
        logic  pend;
        tick_t ticks;
    } snap_t;

    // Steps elapsed inside the current half: 0 at zero, 1 at all-ones,
    // then counting up as the counter falls from the reload value.
    function automatic tick_t half_offset(cnt_t c, tick_t per);
        if (c == '0)
            return '0;
        if (c == '1)
            return tick_t'(1);
        return per - tick_t'(c);
    endfunction

endpackage

// File: rtl/stamp_timer_count.sv
module stamp_timer_count
    import stamp_timer_pkg::*;
#(
    parameter int unsigned RELOAD = 6510
) (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    output cnt_t count,
    output logic half
);

    localparam cnt_t RELOAD_C = cnt_t'(RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            half  <= 1'b1;
        end else if (step_en) begin
            if (count == '0)
                count <= '1;
            else if (count == '1)
                count <= RELOAD_C;
            else
                count <= count - cnt_t'(1);
            if (count == cnt_t'(1))
                half <= ~half;
        end
    end

    p_zero_to_ones_r2: assert property (@(posedge clk) disable iff (rst)
        (step_en && count == '0) |=> (count == '1));
    p_ones_to_reload_r2: assert property (@(posedge clk) disable iff (rst)
        (step_en && count == '1) |=> (count == RELOAD_C));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(count) && $stable(half));
    p_flip_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (step_en && count == cnt_t'(1)) |=> (half != $past(half)));

endmodule

// File: rtl/stamp_timer_tick.sv
module stamp_timer_tick
    import stamp_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  half,
    input  logic  irq_clr,
    output tick_t ticks,
    output logic  irq,
    output logic  pend
);

    logic half_d;

    assign pend = half & ~half_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_d <= 1'b1;
            ticks  <= '0;
            irq    <= 1'b0;
        end else begin
            half_d <= half;
            if (pend)
                ticks <= ticks + tick_t'(1);
            irq <= pend | (irq & ~irq_clr);
        end
    end

    p_tick_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ticks == $past(ticks)) || (ticks == $past(ticks) + tick_t'(1)));
    p_pend_single_r4: assert property (@(posedge clk) disable iff (rst)
        pend |=> !pend);
    p_irq_set_r5: assert property (@(posedge clk) disable iff (rst)
        pend |=> irq);
    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/stamp_timer_snap.sv
module stamp_timer_snap
    import stamp_timer_pkg::*;
#(
    parameter int unsigned RELOAD    = 6510,
    parameter int unsigned EARLY_WIN = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       snap,
    input  cnt_t       count,
    input  logic       half,
    input  logic       pend,
    input  tick_t      ticks,
    input  logic       rd_hi,
    output logic [7:0] rd_byte,
    output tick_t      stamp
);

    localparam tick_t PER     = tick_t'(RELOAD) + tick_t'(2);
    localparam tick_t TWO_PER = PER + PER;
    localparam tick_t WIN     = tick_t'(EARLY_WIN);

    snap_t cap;
    tick_t off;
    tick_t base;
    logic  early;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap.cnt   <= '0;
            cap.half  <= 1'b1;
            cap.pend  <= 1'b0;
            cap.ticks <= '0;
        end else if (snap) begin
            cap.cnt   <= count;
            cap.half  <= half;
            cap.pend  <= pend;
            cap.ticks <= ticks;
        end
    end

    always_comb begin
        off     = half_offset(cap.cnt, PER);
        base    = cap.half ? '0 : PER;
        early   = cap.half & cap.pend & (off < WIN);
        stamp   = (cap.ticks + tick_t'(early)) * TWO_PER + base + off;
        rd_byte = rd_hi ? cap.cnt[CNT_W-1:8] : cap.cnt[7:0];
    end

    p_capture_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(cap));
    p_capture_load_r6: assert property (@(posedge clk) disable iff (rst)
        snap |=> (cap.cnt == $past(count)) && (cap.ticks == $past(ticks)));
    p_offset_range_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (off < PER));

endmodule

// File: rtl/stamp_timer.sv
module stamp_timer
    import stamp_timer_pkg::*;
#(
    parameter int unsigned RELOAD    = 6510,
    parameter int unsigned EARLY_WIN = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step_en,
    input  logic        snap,
    input  logic        irq_clr,
    input  logic        rd_hi,
    output logic [7:0]  rd_byte,
    output logic [63:0] stamp,
    output logic        half_out,
    output logic        irq,
    output logic [63:0] ticks
);

    cnt_t  count;
    logic  half;
    logic  pend;
    tick_t tick_cnt;
    tick_t stamp_w;

    stamp_timer_count #(.RELOAD(RELOAD)) u_count (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .count   (count),
        .half    (half)
    );

    stamp_timer_tick u_tick (
        .clk     (clk),
        .rst     (rst),
        .half    (half),
        .irq_clr (irq_clr),
        .ticks   (tick_cnt),
        .irq     (irq),
        .pend    (pend)
    );

    stamp_timer_snap #(.RELOAD(RELOAD), .EARLY_WIN(EARLY_WIN)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .snap    (snap),
        .count   (count),
        .half    (half),
        .pend    (pend),
        .ticks   (tick_cnt),
        .rd_hi   (rd_hi),
        .rd_byte (rd_byte),
        .stamp   (stamp_w)
    );

    assign half_out = half;
    assign ticks    = tick_cnt;
    assign stamp    = stamp_w;

endmodule

// File: tb/tb_stamp_timer.sv
module tb_stamp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int RLD        = 20;
    localparam int WIN        = 10;
    localparam longint P      = RLD + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic        snap = 1'b0;
    logic        irq_clr = 1'b0;
    logic        rd_hi = 1'b0;
    logic [7:0]  rd_byte;
    logic [63:0] stamp;
    logic        half_out;
    logic        irq;
    logic [63:0] ticks;

    int     n_run  = 0;
    int     n_fail = 0;
    longint n_st   = 0;
    longint cap_n  = 0;
    longint tk     = 0;
    logic   irq_m  = 1'b0;
    logic [63:0] prev_stamp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stamp_timer #(.RELOAD(RLD), .EARLY_WIN(WIN)) dut (
        .clk(clk), .rst(rst), .step_en(step_en), .snap(snap),
        .irq_clr(irq_clr), .rd_hi(rd_hi), .rd_byte(rd_byte),
        .stamp(stamp), .half_out(half_out), .irq(irq), .ticks(ticks)
    );

    function automatic logic [15:0] exp_cnt(longint n);
        longint k = n % P;
        if (k == 0) return 16'h0000;
        if (k == 1) return 16'hFFFF;
        return 16'(P - k);
    endfunction

    function automatic logic exp_half(longint n);
        return ((n / P) % 2) == 0;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic st, input logic sn, input logic cl, input logic hi);
        logic [15:0] ec;
        logic [7:0]  eb;
        longint      nt;
        @(negedge clk);
        step_en = st; snap = sn; irq_clr = cl; rd_hi = hi;
        @(posedge clk);
        if (sn) cap_n = n_st;
        nt = n_st / (2 * P);
        irq_m = (nt != tk) ? 1'b1 : (cl ? 1'b0 : irq_m);
        tk = nt;
        if (st) n_st++;
        #1;
        ec = exp_cnt(cap_n);
        eb = hi ? ec[15:8] : ec[7:0];
        chk(rd_byte == eb, "R2 counter byte", 64'(rd_byte), 64'(eb));
        chk(half_out == exp_half(n_st), "R3 half", 64'(half_out), 64'(exp_half(n_st)));
        chk(ticks == 64'(tk), "R4 ticks", ticks, 64'(tk));
        chk(irq == irq_m, "R5 irq", 64'(irq), 64'(irq_m));
        if (!sn)
            chk(stamp == prev_stamp, "R6 capture hold", stamp, prev_stamp);
        if (cap_n > 0 && (cap_n % (2 * P)) == 0)
            chk(stamp == 64'(cap_n), "R8 early edge stamp", stamp, 64'(cap_n));
        else
            chk(stamp == 64'(cap_n), "R7 stamp", stamp, 64'(cap_n));
        prev_stamp = stamp;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", n_run, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(stamp == 64'd0, "R1 reset stamp", stamp, 64'd0);
        chk(ticks == 64'd0, "R1 reset ticks", ticks, 64'd0);
        chk(irq == 1'b0, "R1 reset irq", 64'(irq), 64'd0);
        chk(half_out == 1'b1, "R1 reset half", 64'(half_out), 64'd1);
        chk(rd_byte == 8'd0, "R1 reset byte", 64'(rd_byte), 64'd0);
        prev_stamp = stamp;

        // Directed: reach the first rising edge, capture in the pending
        // clock together with a clear (R8 correction, R5 set over clear)
        for (int i = 0; i < 2 * P; i++)
            cycle(1'b1, 1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 1'b1, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b1);
        cycle(1'b0, 1'b0, 1'b1, 1'b0);

        // Constrained random mix
        for (int i = 0; i < 4000; i++)
            cycle(($urandom % 8) != 0, ($urandom % 5) == 0,
                  ($urandom % 16) == 0, $urandom % 2);

        // Directed: capture right after an all-ones step
        while ((n_st % P) != 1)
            cycle(1'b1, 1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 1'b0, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule